// File: doc/BRIEF.md
# CAN Receive Bit Sampler with Edge Resynchronization

This block turns an oversampled CAN receive line into a stream of bit decisions, one per nominal bit time. The line is already synchronous to the block clock. While idle the block watches for the line to go dominant (low). That first dominant clock is the start of frame, and it becomes the timing anchor for bit index 0. From then on every sample instant is predicted from the most recent anchor. The prediction is the anchor clock, plus the bit width multiplied by the number of bits sampled since the anchor, plus a sample-point offset.

Each recessive-to-dominant transition seen while bits are being collected moves the anchor to that clock. It also records how many bits had been sampled before it. Timing therefore re-centres on every falling edge instead of drifting freely from the start of frame. The bit width in clocks is the clock rate divided by the nominal bitrate, for example 200 clocks for 1 Mbit/s at 200 MHz. The sample point is given as a percentage of that width, typically 70.

Both settings are captured when a frame starts. A downstream frame parser pulses `frame_end` to send the block back to idle. Stuff bits are not removed: every sampled bit gets its own raw index.

Top module: `can_bit_sampler`

## Requirements
- R1: While `rst_n` is low, `bit_valid` is 0, `raw_bit_index` is 0 and `bit_value` is 1. After reset the block is idle and gives no strobe for as long as `rx_in` stays high.
- R2: In idle, the first clock on which `rx_in` is low starts a frame and becomes the anchor for bit index 0. The first strobe carries `raw_bit_index` 0.
- R3: The effective width W is `bit_clks`, or 2 if `bit_clks` is below 2. The offset is floor(W*P/100), where P is `sp_pct` with values above 100 treated as 100. The offset is then limited to the range 1 to W-1. The first strobe samples the line exactly offset clocks after the anchor clock.
- R4: While no falling edge occurs, successive samples are exactly W clocks apart, and `raw_bit_index` rises by one per strobe.
- R5: A falling edge (line high on one clock, low on the next) while collecting moves the anchor to the clock where the line is first low. The anchor index becomes the number of bits sampled before that clock. The next sample falls at that clock plus W times (the next index minus the anchor index) plus the offset. Rising edges leave the timing unchanged.
- R6: When a falling edge lands on the same clock as a due sample, that bit is still sampled on that clock, with value 0. The edge anchors to that bit's index, so the following sample comes W plus offset clocks later.
- R7: A `frame_end` pulse returns the block to idle. No strobe is issued for a sample due on that clock, and none is issued while idle. The next frame restarts at index 0.
- R8: `bit_valid` is a one-clock pulse for W of 2 or more. It is raised on the clock after the sample clock. `bit_value` is the level of `rx_in` at the sample clock.
- R9: W and the offset are captured at start of frame. Changes to `bit_clks` or `sp_pct` during a frame do not alter that frame's sample timing.
- R10: Asserting `rst_n` low in the middle of a frame abandons the frame. After release no strobe occurs while the line stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_in | input | 1 | Synchronous CAN receive line, 0 = dominant |
| bit_clks | input | BW_W | Nominal bit width in clocks |
| sp_pct | input | PCT_W | Sample point, percent of bit width |
| frame_end | input | 1 | One-clock pulse from the parser, back to idle |
| bit_valid | output | 1 | One-clock strobe per sampled bit |
| bit_value | output | 1 | Line level at the sample clock |
| raw_bit_index | output | IDX_W | Index of the sampled bit, stuff bits counted |

## Verification
The hardest situation to reach is a falling edge that arrives on exactly the clock a sample is due. In that case the old anchor decides the current bit and the new anchor decides the next one. The bench reaches this case by timing a recessive stretch so that it ends on the predicted sample clock of bit 1. It then checks that the third sample moves to W plus offset after that clock, rather than staying on the old grid. A second pattern places an edge between samples and puts a rising edge just before a due sample, which separates resynchronization from free-running timing. A `frame_end` pulse that coincides with a due sample checks that the strobe is suppressed.

// File: rtl/can_bs_pkg.sv
package can_bs_pkg;

  typedef enum logic [0:0] {
    BS_IDLE    = 1'b0,
    BS_COLLECT = 1'b1
  } bs_state_e;

  // Width below two clocks cannot hold a sample point inside the bit.
  function automatic int unsigned eff_width(input int unsigned raw);
    return (raw < 2) ? 2 : raw;
  endfunction

  // Sample-point offset in clocks: truncated percentage, kept inside the bit.
  function automatic int unsigned sp_offset(input int unsigned w, input int unsigned pct);
    int unsigned p;
    int unsigned o;
    p = (pct > 100) ? 100 : pct;
    o = (w * p) / 100;
    if (o < 1) o = 1;
    if (o > w - 1) o = w - 1;
    return o;
  endfunction

  // Clocks after the anchor at which the bit 'delta' positions later is due.
  function automatic int unsigned due_clock(input int unsigned w, input int unsigned delta,
                                            input int unsigned off);
    return w * delta + off;
  endfunction

endpackage

// File: rtl/can_bs_cfg.sv
module can_bs_cfg #(
  parameter int BW_W  = 12,
  parameter int PCT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [BW_W-1:0]  bit_clks_i,
  input  logic [PCT_W-1:0] sp_pct_i,
  output logic [BW_W-1:0]  width_o,
  output logic [BW_W-1:0]  offset_o
);
  import can_bs_pkg::*;

  logic [BW_W-1:0] width_n;
  logic [BW_W-1:0] offset_n;

  always_comb begin
    width_n  = BW_W'(eff_width(32'(bit_clks_i)));
    offset_n = BW_W'(sp_offset(32'(width_n), 32'(sp_pct_i)));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      width_o  <= BW_W'(2);
      offset_o <= BW_W'(1);
    end else if (load_i) begin
      width_o  <= width_n;
      offset_o <= offset_n;
    end
  end
endmodule

// File: rtl/can_bs_edge.sv
module can_bs_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_i,
  output logic fall_o
);
  logic rx_prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) rx_prev_q <= 1'b1;
    else        rx_prev_q <= rx_i;
  end

  assign fall_o = rx_prev_q & ~rx_i;
endmodule

// File: rtl/can_bs_timer.sv
module can_bs_timer #(
  parameter int BW_W  = 12,
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             collect_i,
  input  logic             fall_i,
  input  logic [BW_W-1:0]  width_i,
  input  logic [BW_W-1:0]  offset_i,
  output logic             fire_o,
  output logic [IDX_W-1:0] idx_o
);
  import can_bs_pkg::*;

  localparam int CNT_W = BW_W + IDX_W;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] elapsed_q;
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] anchor_q;
  logic [IDX_W-1:0] delta;
  int unsigned      due;

  always_comb begin
    delta  = idx_q - anchor_q;
    due    = due_clock(32'(width_i), 32'(delta), 32'(offset_i));
    fire_o = collect_i && (32'(elapsed_q) == due);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      elapsed_q <= '0;
      idx_q     <= '0;
      anchor_q  <= '0;
    end else if (start_i) begin
      elapsed_q <= CNT_W'(1);
      idx_q     <= '0;
      anchor_q  <= '0;
    end else if (collect_i) begin
      if (fire_o) idx_q <= idx_q + 1'b1;
      if (fall_i) begin
        elapsed_q <= CNT_W'(1);
        anchor_q  <= idx_q;
      end else if (elapsed_q != CNT_MAX) begin
        elapsed_q <= elapsed_q + 1'b1;
      end
    end
  end

  assign idx_o = idx_q;
endmodule

// File: rtl/can_bit_sampler.sv
module can_bit_sampler #(
  parameter int BW_W  = 12,
  parameter int PCT_W = 7,
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_in,
  input  logic [BW_W-1:0]  bit_clks,
  input  logic [PCT_W-1:0] sp_pct,
  input  logic             frame_end,
  output logic             bit_valid,
  output logic             bit_value,
  output logic [IDX_W-1:0] raw_bit_index
);
  import can_bs_pkg::*;

  bs_state_e        state_q;
  logic             in_idle;
  logic             sof_event;
  logic             fall_raw;
  logic             fall_event;
  logic             sample_fire;
  logic [IDX_W-1:0] idx_now;
  logic [BW_W-1:0]  width_q;
  logic [BW_W-1:0]  offset_q;

  assign in_idle    = (state_q == BS_IDLE);
  assign sof_event  = in_idle & ~rx_in;
  assign fall_event = ~in_idle & fall_raw;

  can_bs_cfg #(.BW_W(BW_W), .PCT_W(PCT_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .load_i(sof_event),
    .bit_clks_i(bit_clks), .sp_pct_i(sp_pct),
    .width_o(width_q), .offset_o(offset_q)
  );

  can_bs_edge u_edge (
    .clk(clk), .rst_n(rst_n), .rx_i(rx_in), .fall_o(fall_raw)
  );

  can_bs_timer #(.BW_W(BW_W), .IDX_W(IDX_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .start_i(sof_event), .collect_i(~in_idle),
    .fall_i(fall_event), .width_i(width_q), .offset_i(offset_q),
    .fire_o(sample_fire), .idx_o(idx_now)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= BS_IDLE;
    end else begin
      unique case (state_q)
        BS_IDLE:    if (!rx_in)    state_q <= BS_COLLECT;
        BS_COLLECT: if (frame_end) state_q <= BS_IDLE;
        default:                   state_q <= BS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_valid     <= 1'b0;
      bit_value     <= 1'b1;
      raw_bit_index <= '0;
    end else begin
      bit_valid <= sample_fire & ~frame_end;
      if (sample_fire & ~frame_end) begin
        bit_value     <= rx_in;
        raw_bit_index <= idx_now;
      end
    end
  end
endmodule

// File: rtl/can_bs_chk.sv
module can_bs_chk #(
  parameter int BW_W  = 12,
  parameter int IDX_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_end,
  input logic             bit_valid,
  input logic [IDX_W-1:0] raw_bit_index,
  input logic             in_idle,
  input logic             fall_event,
  input logic             sample_fire,
  input logic [BW_W-1:0]  width_q,
  input logic [BW_W-1:0]  offset_q
);
  localparam int GAP_W = BW_W + IDX_W;

  logic             have_idx;
  logic [IDX_W-1:0] last_idx;
  logic             have_fire;
  logic             edge_since;
  logic [GAP_W-1:0] gap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      have_idx   <= 1'b0;
      last_idx   <= '0;
      have_fire  <= 1'b0;
      edge_since <= 1'b0;
      gap        <= '0;
    end else begin
      if (in_idle) have_idx <= 1'b0;
      else if (bit_valid) begin
        have_idx <= 1'b1;
        last_idx <= raw_bit_index;
      end
      if (in_idle) begin
        have_fire  <= 1'b0;
        edge_since <= 1'b0;
        gap        <= '0;
      end else if (sample_fire) begin
        have_fire  <= 1'b1;
        edge_since <= fall_event;
        gap        <= GAP_W'(1);
      end else begin
        edge_since <= edge_since | fall_event;
        if (gap != '1) gap <= gap + 1'b1;
      end
    end
  end

  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_idle |-> !bit_valid);

  p_frame_end_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> in_idle);

  p_first_index_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && !have_idx) |-> (raw_bit_index == '0));

  p_index_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && have_idx) |-> (raw_bit_index == last_idx + 1'b1));

  p_strobe_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |=> !bit_valid);

  p_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_fire && have_fire && !edge_since) |-> (32'(gap) == 32'(width_q)));

  p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_idle && $past(!in_idle)) |-> ($stable(width_q) && $stable(offset_q)));

  p_offset_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !in_idle |-> (offset_q >= BW_W'(1) && offset_q < width_q));
endmodule

bind can_bit_sampler can_bs_chk #(.BW_W(BW_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_end(frame_end), .bit_valid(bit_valid),
  .raw_bit_index(raw_bit_index), .in_idle(in_idle), .fall_event(fall_event),
  .sample_fire(sample_fire), .width_q(width_q), .offset_q(offset_q)
);

// File: tb/tb_can_bit_sampler.sv
`timescale 1ns/1ps
module tb_can_bit_sampler;
  localparam int BW_W  = 12;
  localparam int PCT_W = 7;
  localparam int IDX_W = 10;
  localparam int NV    = 6;
  // columns: bit_clks, sp_pct, expected offset, expected effective width
  localparam int TV [NV][4] = '{
    '{10, 70, 7, 10}, '{13, 50, 6, 13}, '{7, 10, 1, 7},
    '{8, 120, 7, 8},  '{1, 50, 1, 2},   '{20, 0, 1, 20}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             rx_in = 1'b1;
  logic [BW_W-1:0]  bit_clks = BW_W'(10);
  logic [PCT_W-1:0] sp_pct = PCT_W'(70);
  logic             frame_end = 1'b0;
  logic             bit_valid;
  logic             bit_value;
  logic [IDX_W-1:0] raw_bit_index;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int ns = 0;
  int dbl = 0;
  logic prev_bv = 1'b0;
  int scyc [64];
  int sidx [64];
  int sval [64];
  int a0;

  always #2.5 clk = ~clk;

  can_bit_sampler #(.BW_W(BW_W), .PCT_W(PCT_W), .IDX_W(IDX_W)) dut (
    .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .bit_clks(bit_clks), .sp_pct(sp_pct),
    .frame_end(frame_end), .bit_valid(bit_valid), .bit_value(bit_value),
    .raw_bit_index(raw_bit_index)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (bit_valid) begin
      if (prev_bv) dbl++;
      if (ns < 64) begin
        scyc[ns] = cyc;
        sidx[ns] = int'(raw_bit_index);
        sval[ns] = int'(bit_value);
      end
      ns++;
    end
    prev_bv = bit_valid;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic seg(input logic v, input int n);
    rx_in = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; rx_in = 1'b1; frame_end = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    ns = 0;
  endtask

  task automatic end_frame();
    rx_in = 1'b1; frame_end = 1'b1;
    @(negedge clk);
    frame_end = 1'b0;
    repeat (2) @(negedge clk);
    ns = 0;
  endtask

  task automatic start_mark();
    a0 = cyc + 1;
    ns = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset values, then idle with a recessive line
    @(negedge clk); @(negedge clk);
    chk("R1 bit_valid in reset", int'(bit_valid), 0);
    chk("R1 index in reset", int'(raw_bit_index), 0);
    chk("R1 value in reset", int'(bit_value), 1);
    rst_n = 1'b1;
    ns = 0;
    seg(1'b1, 40);
    chk("R1 no strobe while idle", ns, 0);

    // R2 R3 R4: table walk over widths and sample points
    for (int i = 0; i < NV; i++) begin
      do_reset();
      bit_clks = BW_W'(TV[i][0]);
      sp_pct   = PCT_W'(TV[i][1]);
      start_mark();
      seg(1'b0, TV[i][2] + 2 * TV[i][3] + 3);
      chk("R3 first sample offset", scyc[0] - a0, TV[i][2]);
      chk("R2 first index", sidx[0], 0);
      chk("R8 first value", sval[0], 0);
      chk("R4 spacing", scyc[1] - scyc[0], TV[i][3]);
      chk("R4 second index", sidx[1], 1);
      end_frame();
    end

    // R5: resync on a falling edge between samples; rising edge ignored
    do_reset();
    bit_clks = BW_W'(10); sp_pct = PCT_W'(70);
    start_mark();
    seg(1'b0, 12); seg(1'b1, 11); seg(1'b0, 30);
    chk("R5 strobe count", ns, 5);
    chk("R5 bit1 after rising edge", scyc[1] - a0, 17);
    chk("R8 bit1 value", sval[1], 1);
    chk("R5 bit2 re-anchored", scyc[2] - a0, 30);
    chk("R5 bit2 index", sidx[2], 2);
    chk("R5 bit4 timing", scyc[4] - a0, 50);
    end_frame();

    // R6: falling edge on the clock a sample is due
    do_reset();
    start_mark();
    seg(1'b0, 5); seg(1'b1, 12); seg(1'b0, 25);
    chk("R6 bit0 value", sval[0], 1);
    chk("R6 coincident sample clock", scyc[1] - a0, 17);
    chk("R6 coincident sample value", sval[1], 0);
    chk("R6 next sample", scyc[2] - a0, 34);
    end_frame();

    // R9: configuration changes mid-frame are ignored
    do_reset();
    start_mark();
    seg(1'b0, 3);
    bit_clks = BW_W'(20); sp_pct = PCT_W'(10);
    seg(1'b0, 25);
    chk("R9 first sample", scyc[0] - a0, 7);
    chk("R9 second sample", scyc[1] - a0, 17);
    end_frame();
    bit_clks = BW_W'(10); sp_pct = PCT_W'(70);

    // R7: frame_end on a due sample suppresses it; idle; restart at 0
    do_reset();
    start_mark();
    seg(1'b0, 7);
    frame_end = 1'b1;
    @(negedge clk);
    frame_end = 1'b0; rx_in = 1'b1;
    @(negedge clk);
    chk("R7 no strobe on frame_end clock", ns, 0);
    seg(1'b1, 40);
    chk("R7 idle after frame_end", ns, 0);
    start_mark();
    seg(1'b0, 20);
    chk("R7 restart first sample", scyc[0] - a0, 7);
    chk("R7 restart index", sidx[0], 0);
    chk("R7 restart second index", sidx[1], 1);
    end_frame();

    // R10: reset in the middle of a frame
    start_mark();
    seg(1'b0, 3);
    rst_n = 1'b0; rx_in = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    ns = 0;
    seg(1'b1, 30);
    chk("R10 no strobe after mid-frame reset", ns, 0);

    // R8: strobe never held two clocks
    chk("R8 single-clock strobe", dbl, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule